// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses for a single SDRAM read or write burst. A one-cycle start pulse loads a starting column, a burst-length code, a wrap-ordering bit and a write flag. From the next cycle on, the block presents one column address per beat on a valid/ready output stream. A last flag marks the final beat of a fixed-length burst.

Within a fixed-length burst, the address wraps inside an aligned block of the burst length. The order is either sequential (low bits count up modulo the length) or interleaved (low bits XORed with the beat index). A full-page burst walks the whole column range, wraps at the page size, and runs until it is stopped. A burst-stop or precharge input ends any burst early. A new start on any cycle cuts off the running burst. An option limits every write to a single beat, while reads keep the requested length.

Back-pressure: a beat is transferred on a cycle where `valid_o` and `ready_i` are both high. While `ready_i` is low, the address, the last flag and the valid level are held. The burst-stop, precharge and start inputs act whatever the level of `ready_i`.

Top module: `sdram_colgen`

## Requirements
- R1: After reset, `valid_o` and `last_o` are low.
- R2: A start pulse sampled on a clock edge makes `valid_o` high after that edge, and the first address equals the starting column.
- R3: The length code sets the beat count: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and 4 to 6 give 1. `last_o` is high only on the final beat of a fixed-length burst.
- R4: In sequential order (`ilv_mode_i`=0), beat n carries the starting column with its low log2(L) bits replaced by (low bits + n) mod L. The upper bits do not change.
- R5: In interleaved order (`ilv_mode_i`=1), beat n of a length-L burst is the starting column with its low log2(L) bits XORed with n.
- R6: A full-page burst increments the whole column by one per beat, wraps from PAGE_COLS-1 to 0, and never raises `last_o`.
- R7: A burst-stop or precharge sampled high (without start) lets the beat shown in that cycle complete, if ready, and `valid_o` is low from the next cycle.
- R8: A start while a burst runs drops the rest of the old burst, and the next cycle shows the new starting column.
- R9: With `single_wr_en_i`=1 and `wr_i`=1 at start, the burst is one beat whatever the code. Reads, and writes with the option off, keep the coded length.
- R10: While `valid_o` is high and `ready_i` is low (no start, stop or precharge), the next cycle keeps `valid_o` high and `col_o` unchanged.
- R11: After the beat with `last_o` is accepted, `valid_o` is low on the next cycle unless a start was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | COL_W | Starting column |
| bl_code_i | input | 3 | Burst-length code |
| ilv_mode_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| wr_i | input | 1 | Burst is a write |
| single_wr_en_i | input | 1 | Force writes to one beat |
| bst_i | input | 1 | Burst-stop command |
| pre_i | input | 1 | Precharge command |
| ready_i | input | 1 | Consumer accepts the beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Starting columns are chosen with non-zero low bits, so that sequential and interleaved ordering give different sequences. An interleaved run at length 8 from an odd offset cannot pass a sequential model, and the reverse also holds. A full-page run starts two columns below the page end, which exposes any wrap at the burst boundary instead of at the page boundary. Stop, precharge and restart are each applied mid-burst, which shows whether surplus beats leak out. A ready pattern with gaps checks that stalled beats are held and never skipped.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
  localparam int MAX_BL     = 8;
  localparam int MAX_BL_LOG = $clog2(MAX_BL);

  typedef logic [MAX_BL_LOG-1:0] beat_t;
  typedef logic [1:0]            len_log_t;

  typedef enum logic [2:0] {
    BLC_1    = 3'd0,
    BLC_2    = 3'd1,
    BLC_4    = 3'd2,
    BLC_8    = 3'd3,
    BLC_PAGE = 3'd7
  } bl_code_e;

  typedef struct packed {
    len_log_t len_log;
    logic     full;
  } burst_shape_t;

  function automatic beat_t last_beat(input len_log_t ll);
    logic [MAX_BL_LOG:0] one_hot;
    one_hot = (MAX_BL_LOG+1)'(1) << ll;
    return beat_t'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import sdram_colgen_pkg::*;
(
  input  logic [2:0]   code_i,
  input  logic         wr_i,
  input  logic         single_wr_en_i,
  output burst_shape_t shape_o
);
  burst_shape_t raw;

  always_comb begin
    raw = '{len_log: 2'd0, full: 1'b0};
    unique case (code_i)
      BLC_1:    raw.len_log = 2'd0;
      BLC_2:    raw.len_log = 2'd1;
      BLC_4:    raw.len_log = 2'd2;
      BLC_8:    raw.len_log = 2'd3;
      BLC_PAGE: raw.full    = 1'b1;
      default:  raw.len_log = 2'd0;
    endcase
  end

  always_comb begin
    shape_o = raw;
    if (single_wr_en_i && wr_i) begin
      shape_o.len_log = 2'd0;
      shape_o.full    = 1'b0;
    end
  end
endmodule

// File: rtl/colgen_next_col.sv
module colgen_next_col
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W     = 9,
  parameter int PAGE_COLS = 512
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cur_i,
  input  beat_t            beat_nxt_i,
  input  burst_shape_t     shape_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] nxt_o
);
  localparam int LB = MAX_BL_LOG;
  localparam logic [COL_W-1:0] PAGE_END = COL_W'(PAGE_COLS - 1);

  beat_t            base_lo, seq_lo, ilv_lo, pick_lo, new_lo;
  logic [LB-1:0]    mask;
  logic [COL_W-1:0] fixed_col, page_col;

  assign base_lo = base_i[LB-1:0];
  assign seq_lo  = base_lo + beat_nxt_i;
  assign ilv_lo  = base_lo ^ beat_nxt_i;
  assign pick_lo = ilv_i ? ilv_lo : seq_lo;

  for (genvar b = 0; b < LB; b++) begin : g_lo
    assign mask[b]   = (int'(shape_i.len_log) > b);
    assign new_lo[b] = mask[b] ? pick_lo[b] : base_lo[b];
  end

  assign fixed_col = {base_i[COL_W-1:LB], new_lo};
  assign page_col  = (cur_i == PAGE_END) ? '0 : cur_i + 1'b1;
  assign nxt_o     = shape_i.full ? page_col : fixed_col;
endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  burst_shape_t     shape_in_i,
  input  logic             ilv_in_i,
  input  logic             end_i,
  input  logic             ready_i,
  input  logic [COL_W-1:0] nxt_col_i,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cur_o,
  output beat_t            beat_nxt_o,
  output burst_shape_t     shape_o,
  output logic             ilv_o,
  output logic             valid_o,
  output logic             last_o
);
  logic  active_q;
  beat_t beat_q;
  logic  at_end;

  assign at_end     = !shape_o.full && (beat_q == last_beat(shape_o.len_log));
  assign beat_nxt_o = beat_q + 1'b1;
  assign valid_o    = active_q;
  assign last_o     = active_q && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_o   <= '0;
      cur_o    <= '0;
      shape_o  <= '0;
      ilv_o    <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_o   <= start_col_i;
      cur_o    <= start_col_i;
      shape_o  <= shape_in_i;
      ilv_o    <= ilv_in_i;
    end else if (active_q) begin
      if (end_i) begin
        active_q <= 1'b0;
      end else if (ready_i) begin
        if (at_end) begin
          active_q <= 1'b0;
        end else begin
          beat_q <= beat_nxt_o;
          cur_o  <= nxt_col_i;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_colgen.sv
module sdram_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W     = 9,
  parameter int PAGE_COLS = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_mode_i,
  input  logic             wr_i,
  input  logic             single_wr_en_i,
  input  logic             bst_i,
  input  logic             pre_i,
  input  logic             ready_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  burst_shape_t     shape_in, shape_q;
  logic [COL_W-1:0] base_q, cur_q, nxt_col;
  beat_t            beat_nxt;
  logic             ilv_q;

  colgen_len_decode u_dec (
    .code_i         (bl_code_i),
    .wr_i           (wr_i),
    .single_wr_en_i (single_wr_en_i),
    .shape_o        (shape_in)
  );

  colgen_next_col #(.COL_W(COL_W), .PAGE_COLS(PAGE_COLS)) u_nxt (
    .base_i     (base_q),
    .cur_i      (cur_q),
    .beat_nxt_i (beat_nxt),
    .shape_i    (shape_q),
    .ilv_i      (ilv_q),
    .nxt_o      (nxt_col)
  );

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .shape_in_i  (shape_in),
    .ilv_in_i    (ilv_mode_i),
    .end_i       (bst_i | pre_i),
    .ready_i     (ready_i),
    .nxt_col_i   (nxt_col),
    .base_o      (base_q),
    .cur_o       (cur_q),
    .beat_nxt_o  (beat_nxt),
    .shape_o     (shape_q),
    .ilv_o       (ilv_q),
    .valid_o     (valid_o),
    .last_o      (last_o)
  );

  assign col_o = cur_q;
endmodule

// File: rtl/sdram_colgen_chk.sv
module sdram_colgen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             bst_i,
  input logic             pre_i,
  input logic             ready_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  // R3
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  // R7
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bst_i || pre_i) && !start_i) |=> !valid_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !start_i && !bst_i && !pre_i) |=> (valid_o && $stable(col_o)));

  // R11
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && last_o && !start_i) |=> !valid_o);
endmodule

bind sdram_colgen sdram_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .bst_i       (bst_i),
  .pre_i       (pre_i),
  .ready_i     (ready_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/sdram_colgen_bench.sv
`timescale 1ns/100ps
module sdram_colgen_bench;
  localparam int COL_W = 9;
  localparam int PAGE  = 512;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start_i = 1'b0, ilv_mode_i = 1'b0, wr_i = 1'b0;
  logic single_wr_en_i = 1'b0, bst_i = 1'b0, pre_i = 1'b0, ready_i = 1'b1;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o;

  sdram_colgen #(.COL_W(COL_W), .PAGE_COLS(PAGE)) u_sdram_colgen (.*);

  int    checks = 0, bad = 0, cyc = 0;
  bit    bp_en = 1'b0;
  int    q_col[$];
  bit    q_last[$];
  string q_tag[$];
  bit    stall_prev = 1'b0;
  int    stall_col = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int blen(input int code, input bit wr, input bit opt);
    if (wr && opt) return 1;
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int c0, input int len, input bit ilv, input int i);
    if (len == 0) return (c0 + i) % PAGE;
    if (ilv) return c0 ^ i;
    return c0 - (c0 % len) + ((c0 % len + i) % len);
  endfunction

  // ready pattern: gaps every third cycle when back-pressure is on
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    ready_i = !bp_en || (cyc % 3 != 0);
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (stall_prev && valid_o) chk(int'(col_o) == stall_col, "R10 hold", col_o, stall_col);
    if (valid_o && ready_i) begin
      if (q_col.size() == 0) chk(1'b0, "R7 extra beat", col_o, -1);
      else begin
        int ec; bit el; string t;
        ec = q_col.pop_front(); el = q_last.pop_front(); t = q_tag.pop_front();
        chk(int'(col_o) == ec, t, col_o, ec);
        chk(last_o == el, {t, " R3 last"}, last_o, el);
      end
    end
    stall_prev = valid_o && !ready_i && !start_i && !bst_i && !pre_i;
    stall_col  = col_o;
  end

  // kind: 0 run to end, 1 burst-stop, 2 precharge, 3 leave for restart
  task automatic burst(input int c0, input int code, input bit ilv, input bit wr,
                       input bit opt, input int cut, input int kind, input string tag);
    int len, n;
    len = blen(code, wr, opt);
    n = (len == 0 || (kind != 0 && cut < len)) ? cut : len;
    for (int i = 0; i < n; i++) begin
      q_col.push_back(exp_col(c0, len, ilv, i));
      q_last.push_back(len != 0 && i == len - 1);
      q_tag.push_back(i == 0 ? {tag, " R2"} : tag);
    end
    @(posedge clk); #1;
    start_i = 1'b1; start_col_i = COL_W'(c0); bl_code_i = 3'(code);
    ilv_mode_i = ilv; wr_i = wr; single_wr_en_i = opt;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (kind == 0) begin
      for (int w = 0; w < 100 && q_col.size() != 0; w++) @(negedge clk);
      @(negedge clk);
      chk(!valid_o, {tag, " R11 valid drop"}, valid_o, 0);
    end else if (kind == 3) begin
      repeat (cut - 2) begin @(posedge clk); #1; end
    end else begin
      repeat (cut - 1) begin @(posedge clk); #1; end
      if (kind == 1) bst_i = 1'b1; else pre_i = 1'b1;
      @(posedge clk); #1;
      bst_i = 1'b0; pre_i = 1'b0;
      @(negedge clk);
      chk(!valid_o, {tag, " R7 ended"}, valid_o, 0);
      chk(q_col.size() == 0, {tag, " R7 beats"}, q_col.size(), 0);
    end
  endtask

  bit done = 1'b0;
  initial begin
    #(5 * 20000);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!valid_o, "R1 valid", valid_o, 0);
    chk(!last_o, "R1 last", last_o, 0);
    burst(5,   1, 0, 0, 0, 0, 0, "R4 seq2");
    burst(14,  2, 0, 0, 0, 0, 0, "R4 seq4");
    burst(29,  3, 0, 0, 0, 0, 0, "R4 seq8");
    burst(29,  3, 1, 0, 0, 0, 0, "R5 ilv8");
    burst(6,   2, 1, 0, 0, 0, 0, "R5 ilv4");
    burst(100, 0, 0, 0, 0, 0, 0, "R3 len1");
    burst(200, 5, 0, 0, 0, 0, 0, "R3 reserved");
    burst(510, 7, 0, 0, 0, 5, 1, "R6 page");
    burst(40,  3, 0, 0, 0, 3, 2, "R7 pre");
    burst(64,  3, 0, 0, 0, 3, 3, "R8 old");
    burst(3,   1, 1, 0, 0, 0, 0, "R8 new");
    burst(50,  3, 0, 1, 1, 0, 0, "R9 wr single");
    burst(50,  3, 0, 0, 1, 0, 0, "R9 rd kept");
    burst(50,  3, 1, 1, 0, 0, 0, "R9 opt off");
    bp_en = 1'b1;
    burst(77,  3, 1, 0, 0, 0, 0, "R10 bp");
    burst(33,  2, 0, 0, 0, 0, 0, "R10 bp seq");
    bp_en = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule